// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer that raises an interrupt request toward a local priority unit. Software programs it through a small register port. A divide setting picks a power-of-two prescale of the core clock. A start value loads the counter, and the counter counts down once per prescaled tick. A control entry holds the interrupt vector, a mask and the choice between single-shot and repeating operation.

When the count moves from 1 to 0, the block emits a one-cycle request carrying the vector. The mask suppresses this request. A repeating timer reloads its start value on the tick after reaching zero, so each period lasts start+1 ticks. A single-shot timer stays at zero. Writing a start value of zero leaves the timer idle.

Top module: `tick_down_timer`

## Requirements
- R1: The register offsets are: 0 for the control entry, 1 for the start value, 2 for the current count (read-only), and 3 for the divide setting. A write to offset 3 keeps only bits 0, 1 and 3 (mask 0xB), and that masked value is what reads back.
- R2: The prescale code is {bit3, bit1, bit0} of the divide setting. The counter steps once every 2^((code+1) mod 8) clock cycles, so 0xB divides by 1, 0x0 by 2, 0x1 by 4, 0x3 by 16, 0x8 by 32 and 0xA by 128.
- R3: A write to the start value loads the current count with that value and clears the prescaler. The first step therefore comes one full prescale period after the write. A new write while the timer runs restarts the timing from that write.
- R4: In single-shot mode (control bit 17 = 0), the count decreases by one per tick. A request is raised N ticks after a start value N is written. The count then stays at 0 and no further request follows.
- R5: In repeating mode (control bit 17 = 1), a count of 0 reloads the start value on the next tick. After the first request, requests recur every N+1 ticks.
- R6: The request `irq_req` is high for exactly one cycle, right after the clock edge on which the count goes from 1 to 0. `irq_vec` then carries control bits 7:0. When control bit 16 (mask) is set, no request is raised, but counting continues.
- R7: A start value of 0 leaves the count at 0, and no request is ever raised.
- R8: `reg_rdata` returns, one cycle later, the register selected by `reg_addr`. The control entry reads back only bits 7:0, 16 and 17. Writes to offset 2 have no effect.
- R9: After reset, all registers, the count and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| irq_req | output | 1 | One-cycle interrupt request (edge type) |
| irq_vec | output | 8 | Vector accompanying the request |

## Verification
The checks assume the register port writes at most one offset per cycle. They also assume a start-value write supersedes any step or expiry in the same cycle. The bench drives each write for exactly one clock and leaves the port idle otherwise. It measures request timing only after the divide and control writes have settled, and always from the start-value write. It issues no reset in the middle of a run, so the past-value properties only ever see values from after reset.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_START = 2'd1,
    REG_COUNT = 2'd2,
    REG_DIV   = 2'd3
  } reg_sel_e;

  localparam int VEC_W     = 8;
  localparam int MASK_BIT  = 16;
  localparam int REPEAT_BIT = 17;
  localparam int DIV_W     = 4;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;
  localparam int SHIFT_W   = 3;

  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
  parameter int SHIFT_W = 3,
  localparam int PRE_W = (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] sel;

  always_comb begin
    span = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
    sel  = span[PRE_W-1:0];
    tick = ((pre_q & sel) == sel);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             repeat_mode,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign expire = tick && !load && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      if (count != '0)      count <= count - ONE;
      else if (repeat_mode) count <= reload_val;
    end
  end
endmodule

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic              start_load,
  output logic [CNT_W-1:0]  start_val,
  output logic [VEC_W-1:0]  vec,
  output logic              masked,
  output logic              repeat_mode,
  output logic [DIV_W-1:0]  div_cfg,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  reg_sel_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel        = reg_sel_e'(addr);
  assign start_load = wr && (sel == REG_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec         <= '0;
      masked      <= 1'b0;
      repeat_mode <= 1'b0;
      start_val   <= '0;
      div_cfg     <= '0;
    end else if (wr) begin
      case (sel)
        REG_CTRL: begin
          vec         <= wdata[VEC_W-1:0];
          masked      <= wdata[MASK_BIT];
          repeat_mode <= wdata[REPEAT_BIT];
        end
        REG_START: start_val <= wdata[CNT_W-1:0];
        REG_DIV:   div_cfg   <= wdata[DIV_W-1:0] & DIV_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[VEC_W-1:0]  = vec;
        rd_mux[MASK_BIT]   = masked;
        rd_mux[REPEAT_BIT] = repeat_mode;
      end
      REG_START: rd_mux[CNT_W-1:0] = start_val;
      REG_COUNT: rd_mux[CNT_W-1:0] = count;
      REG_DIV:   rd_mux[DIV_W-1:0] = div_cfg;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      rdata   <= rd_mux;
      irq_req <= expire && !masked;
      if (expire) irq_vec <= vec;
    end
  end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic              load_w;
  logic [CNT_W-1:0]  start_w;
  logic [VEC_W-1:0]  vec_w;
  logic              mask_w;
  logic              rep_w;
  logic [DIV_W-1:0]  div_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              exp_w;
  logic              tick_w;

  tdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .count(cnt_w), .expire(exp_w), .start_load(load_w), .start_val(start_w),
    .vec(vec_w), .masked(mask_w), .repeat_mode(rep_w), .div_cfg(div_w),
    .rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  tdt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .clear(load_w), .shift(div_to_shift(div_w)),
    .tick(tick_w)
  );

  tdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_w), .load_val(reg_wdata[CNT_W-1:0]),
    .reload_val(start_w), .repeat_mode(rep_w), .tick(tick_w),
    .count(cnt_w), .expire(exp_w)
  );
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int CNT_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  start_val,
  input logic              tick,
  input logic              rep,
  input logic              masked,
  input logic [7:0]        vec,
  input logic              irq_req,
  input logic [7:0]        irq_vec
);
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(wdata[CNT_W-1:0]));

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count > 1) |=> count == $past(count) - 1);

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (!rep && !load && count == '0) |=> count == '0);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !$past(masked));

  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_vec == $past(vec));

  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (start_val == '0 && !load) |=> count == '0 || $past(count) != '0);
endmodule

bind tick_down_timer tdt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .load(load_w), .wdata(reg_wdata), .count(cnt_w),
  .start_val(start_w), .tick(tick_w), .rep(rep_w), .masked(mask_w),
  .vec(vec_w), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/tb_tick_down_timer.sv
module tb_tick_down_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tick_down_timer dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec)
  );

  // {divide setting[3:0], start value[15:0], expected cycles to request[15:0]}
  localparam logic [35:0] VECS [7] = '{
    {4'hB, 16'd5, 16'd5},
    {4'h0, 16'd3, 16'd6},
    {4'h1, 16'd4, 16'd16},
    {4'h3, 16'd2, 16'd32},
    {4'h8, 16'd1, 16'd32},
    {4'hA, 16'd2, 16'd256},
    {4'h4, 16'd3, 16'd6}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (irq_req) break;
    end
  endtask

  task automatic count_irq(input int cyc, output int n);
    n = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (irq_req) n++;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(irq_req == 1'b0, "R9 irq", {31'd0, irq_req}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d == 0, "R9 reg", d, 0);
    end

    // table walk: R2 divide decoding, R4 single-shot timing, R6 vector
    for (int i = 0; i < 7; i++) begin
      wr(2'd3, {28'd0, VECS[i][35:32]});
      wr(2'd0, 32'h20 + i);
      wr(2'd1, {16'd0, VECS[i][31:16]});
      wait_irq(400, n);
      chk(n == int'(VECS[i][15:0]), "R2 R4 timing", n, VECS[i][15:0]);
      chk(irq_vec == 8'(32'h20 + i), "R6 vector", irq_vec, 32'h20 + i);
    end

    // R1 divide mask
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d);
    chk(d == 32'hB, "R1 divide readback", d, 32'hB);

    // R8 control readback, start readback
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk(d == 32'h0003_00FF, "R8 control readback", d, 32'h0003_00FF);
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h1234);
    rd(2'd2, d);
    chk(d == 0, "R8 count write ignored", d, 0);

    // R3 load value visible, divide by 2
    wr(2'd3, 32'h0);
    wr(2'd1, 32'd7);
    rd(2'd2, d);
    chk(d == 32'd7, "R3 load", d, 7);

    // R4 saturate
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd3);
    wait_irq(50, n);
    chk(n == 3, "R4 first", n, 3);
    count_irq(20, n);
    chk(n == 0, "R4 no repeat", n, 0);
    rd(2'd2, d);
    chk(d == 0, "R4 stays zero", d, 0);

    // R3 restart
    wr(2'd1, 32'd10);
    repeat (4) @(posedge clk);
    wr(2'd1, 32'd3);
    wait_irq(50, n);
    chk(n == 3, "R3 restart", n, 3);

    // R5 repeating
    wr(2'd0, 32'h0002_0077);
    wr(2'd1, 32'd2);
    wait_irq(50, n);
    chk(n == 2, "R5 first", n, 2);
    wait_irq(50, n);
    chk(n == 3, "R5 period", n, 3);
    wait_irq(50, n);
    chk(n == 3, "R5 period again", n, 3);
    chk(irq_vec == 8'h77, "R6 repeat vector", irq_vec, 32'h77);

    // R6 mask
    wr(2'd0, 32'h0001_0055);
    wr(2'd1, 32'd2);
    count_irq(12, n);
    chk(n == 0, "R6 masked", n, 0);
    rd(2'd2, d);
    chk(d == 0, "R6 masked counting", d, 0);

    // R7 start of zero
    wr(2'd0, 32'h0002_0033);
    wr(2'd1, 32'd0);
    count_irq(30, n);
    chk(n == 0, "R7 idle", n, 0);
    rd(2'd2, d);
    chk(d == 0, "R7 count zero", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule